// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns up to 32 external interrupt pins into masked, latched interrupt requests for a processor. Each pin is brought into the clock domain through a short flop chain. It is then judged against its own sense setting: active-low level, active-high level, falling edge, rising edge, or either edge. A sensed event sets a sticky detect bit. Software clears detect bits by writing ones to them.

The mask has two write-one registers. One of them only sets enable bits and the other only clears them, so software can change one pin's mask with no read-modify-write. The request seen by the processor is the detect bit ANDed with the enable bit. It appears both as one interrupt line per pin and as a readable request register. A monitor register and a matching output bus show the synchronized pin levels.

Access is through a plain 32-bit register port: `addr_i`, `wr_en_i`, `wr_data_i`, and a combinational `rd_data_o` for the current address. There is no stream traffic, so no valid/ready handshake is used. A write takes effect at the clock edge on which `wr_en_i` is high. A read is valid in the same cycle.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: Reset clears every enable bit, every detect bit and every sense setting. While reset is held, all interrupt outputs are low.
- R2: Writing to offset 0x008 sets enable bit n for each 1 in bit n of the written data. Zero bits leave the mask unchanged. Reads of 0x004 and of 0x008 both return the current mask.
- R3: Writing to offset 0x004 clears enable bit n for each 1 in bit n of the written data. Zero bits leave the mask unchanged.
- R4: Offset 0x100 reads the detect bits. A detect bit stays set until software writes a 1 to it at 0x100. A sensed event in the same cycle as that write wins over the clear.
- R5: Offset 0x104 and `pin_level_o` return the synchronized pin levels. Each pin passes through two flops, so a pin change shows after the second rising clock edge.
- R6: Pin n has a sense register at 0x180 + 4*n. Bits [5:0] hold its sense code and read back as written. Bits above 5 are not stored and read as zero.
- R7: Code 0x02 (active high) or 0x01 (active low) sets the detect bit on every cycle the synchronized level is active. A clear therefore holds only once the pin is inactive.
- R8: Code 0x08 detects a rising edge, code 0x04 a falling edge, and code 0x0C either edge. An edge is a difference between two successive synchronized samples.
- R9: Any sense code other than 0x01, 0x02, 0x04, 0x08 or 0x0C senses nothing, whatever the pin does.
- R10: Offset 0x000 reads detect AND enable, and `irq_o` carries the same vector. Writes to 0x000 change nothing.
- R11: In an edge or level mode, a pin change driven between clock edges sets its detect bit at the third rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous |
| addr_i | input | 12 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the current address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for the current address |
| pin_i | input | N_PINS | External interrupt pins |
| irq_o | output | N_PINS | Masked interrupt request per pin |
| pin_level_o | output | N_PINS | Synchronized pin levels |

## Verification
A wrong enable or detect bit shows at once, in the same cycle, on `irq_o` and on the request register. A lost edge, or a level that fails to re-set its bit, shows at the detect register three edges after the pin moves. A wrong synchronizer depth shifts the cycle in which both the monitor and the detect bit change, so it is seen by exact-cycle sampling. A misdecoded sense code shows in the next settled check, either as a spurious detect bit or as a missing one.

// File: rtl/eisc_pkg.sv
package eisc_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 12;
  localparam int SENSE_W = 6;
  localparam int MAX_PINS = 32;

  localparam logic [ADDR_W-1:0] OFS_REQ    = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DET    = 12'h100;
  localparam logic [ADDR_W-1:0] OFS_MON    = 12'h104;
  localparam logic [ADDR_W-1:0] OFS_CFG    = 12'h180;

  typedef enum logic [SENSE_W-1:0] {
    SNS_OFF  = 6'h00,
    SNS_LOW  = 6'h01,
    SNS_HIGH = 6'h02,
    SNS_FALL = 6'h04,
    SNS_RISE = 6'h08,
    SNS_BOTH = 6'h0C
  } sense_e;
endpackage

// File: rtl/eisc_pin_sync.sv
module eisc_pin_sync #(
  parameter int N_PINS      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] lvl_o,
  output logic [N_PINS-1:0] prev_o
);
  logic [N_PINS-1:0] stage_q [SYNC_STAGES];
  logic [N_PINS-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) begin
        if (!rst_ni) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= pin_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= stage_q[SYNC_STAGES-1];
  end

  assign lvl_o  = stage_q[SYNC_STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/eisc_sense_decode.sv
module eisc_sense_decode
  import eisc_pkg::*;
(
  input  logic [SENSE_W-1:0] code_i,
  input  logic               lvl_i,
  input  logic               prev_i,
  output logic               evt_o
);
  logic rise, fall;
  assign rise = lvl_i & ~prev_i;
  assign fall = ~lvl_i & prev_i;

  always_comb begin
    unique case (code_i)
      SNS_LOW:  evt_o = ~lvl_i;
      SNS_HIGH: evt_o = lvl_i;
      SNS_FALL: evt_o = fall;
      SNS_RISE: evt_o = rise;
      SNS_BOTH: evt_o = rise | fall;
      default:  evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
  import eisc_pkg::*;
#(
  parameter int N_PINS      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [11:0]       addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] irq_o,
  output logic [N_PINS-1:0] pin_level_o
);
  localparam int IDX_W = $clog2(MAX_PINS);

  logic [N_PINS-1:0]  lvl, prev, evt;
  logic [N_PINS-1:0]  en_q, det_q, req;
  logic [SENSE_W-1:0] cfg_q [N_PINS];
  logic [N_PINS-1:0]  wdat;

  logic               cfg_hit;
  logic [IDX_W-1:0]   cfg_idx;
  logic               wr_set, wr_clr, wr_det;

  assign wdat    = wr_data_i[N_PINS-1:0];
  assign wr_set  = wr_en_i && (addr_i == OFS_EN_SET);
  assign wr_clr  = wr_en_i && (addr_i == OFS_EN_CLR);
  assign wr_det  = wr_en_i && (addr_i == OFS_DET);
  assign cfg_hit = (addr_i[ADDR_W-1:7] == OFS_CFG[ADDR_W-1:7]) && (addr_i[1:0] == 2'b00);
  assign cfg_idx = addr_i[2 +: IDX_W];

  eisc_pin_sync #(.N_PINS(N_PINS), .SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  genvar n;
  generate
    for (n = 0; n < N_PINS; n++) begin : g_pin
      eisc_sense_decode dec_i (
        .code_i (cfg_q[n]),
        .lvl_i  (lvl[n]),
        .prev_i (prev[n]),
        .evt_o  (evt[n])
      );

      always_ff @(posedge clk_i) begin
        if (!rst_ni) cfg_q[n] <= '0;
        else if (wr_en_i && cfg_hit && (cfg_idx == IDX_W'(n)))
          cfg_q[n] <= wr_data_i[SENSE_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      en_q  <= '0;
      det_q <= '0;
    end else begin
      if (wr_set)      en_q <= en_q | wdat;
      else if (wr_clr) en_q <= en_q & ~wdat;
      det_q <= (det_q & ~(wr_det ? wdat : '0)) | evt;
    end
  end

  assign req         = det_q & en_q;
  assign irq_o       = req;
  assign pin_level_o = lvl;

  always_comb begin
    rd_data_o = '0;
    if (cfg_hit) begin
      if (int'(cfg_idx) < N_PINS) rd_data_o = REG_W'(cfg_q[cfg_idx]);
    end else begin
      unique case (addr_i)
        OFS_REQ:    rd_data_o = REG_W'(req);
        OFS_EN_CLR: rd_data_o = REG_W'(en_q);
        OFS_EN_SET: rd_data_o = REG_W'(en_q);
        OFS_DET:    rd_data_o = REG_W'(det_q);
        OFS_MON:    rd_data_o = REG_W'(lvl);
        default:    rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/eisc_checker.sv
module eisc_checker
  import eisc_pkg::*;
#(
  parameter int N_PINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [11:0]       addr_i,
  input logic              wr_en_i,
  input logic [31:0]       wr_data_i,
  input logic [N_PINS-1:0] en_q,
  input logic [N_PINS-1:0] det_q,
  input logic [N_PINS-1:0] evt,
  input logic [N_PINS-1:0] irq_o
);
  logic [N_PINS-1:0] wd;
  assign wd = wr_data_i[N_PINS-1:0];

  p_reset_clear_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (en_q == '0 && det_q == '0 && irq_o == '0));

  p_en_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_EN_SET) |=> ((en_q & $past(wd)) == $past(wd)));

  p_en_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_EN_CLR) |=> ((en_q & $past(wd)) == '0));

  p_det_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFS_DET) |=> ((det_q & $past(wd) & ~$past(evt)) == '0));

  p_det_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == OFS_DET) |=> ((det_q & $past(det_q)) == $past(det_q)));

  p_irq_masked_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_o & ~en_q) == '0));
endmodule

bind ext_irq_sense_ctrl eisc_checker #(.N_PINS(N_PINS)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .en_q      (en_q),
  .det_q     (det_q),
  .evt       (evt),
  .irq_o     (irq_o)
);

// File: tb/ext_irq_sense_ctrl_tb_top.sv
module ext_irq_sense_ctrl_tb_top;
  localparam int  NP     = 32;
  localparam time CLK_PS = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] irq, mon;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NP-1:0] en_m = '0;
  logic [NP-1:0] det_m = '0;
  logic [5:0]    cfg_m [NP];

  always #(CLK_PS/2) clk = ~clk;

  ext_irq_sense_ctrl #(.N_PINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .pin_i(pins),
    .irq_o(irq), .pin_level_o(mon)
  );

  function automatic bit sense_f(logic [5:0] c, bit o, bit n);
    case (c)
      6'h01:   return !n;
      6'h02:   return n;
      6'h04:   return o && !n;
      6'h08:   return !o && n;
      6'h0C:   return o != n;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [NP-1:0] active_f(logic [NP-1:0] o, logic [NP-1:0] n);
    logic [NP-1:0] r;
    for (int i = 0; i < NP; i++) r[i] = sense_f(cfg_m[i], o[i], n[i]);
    return r;
  endfunction

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [31:0] d;
    rd(12'h004, d); chk({tag, " R2 mask@004"}, d, en_m);
    rd(12'h008, d); chk({tag, " R2 mask@008"}, d, en_m);
    rd(12'h100, d); chk({tag, " R4 detect"}, d, det_m);
    rd(12'h000, d); chk({tag, " R10 request"}, d, det_m & en_m);
    chk({tag, " R10 irq_o"}, irq, det_m & en_m);
    rd(12'h104, d); chk({tag, " R5 monitor"}, d, pins);
    chk({tag, " R5 pin_level_o"}, mon, pins);
  endtask

  task automatic set_cfg(int p, logic [31:0] d);
    wr(12'h180 + 12'(4*p), d);
    cfg_m[p] = d[5:0];
    settle();
    det_m |= active_f(pins, pins);
  endtask

  task automatic move_pins(logic [NP-1:0] n);
    logic [NP-1:0] o;
    o = pins;
    @(negedge clk);
    pins = n;
    settle();
    det_m |= active_f(o, n);
  endtask

  task automatic clear_det(logic [NP-1:0] m);
    wr(12'h100, m);
    det_m = (det_m & ~m) | active_f(pins, pins);
  endtask

  initial begin
    #(CLK_PS * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog R1 got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240517));
    for (int i = 0; i < NP; i++) cfg_m[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 irq during reset", irq, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after reset");
    rd(12'h180, d); chk("R1 cfg0 cleared", d, 0);
    rd(12'h1FC, d); chk("R1 cfg31 cleared", d, 0);

    // R6: config readback, upper bits not stored
    set_cfg(31, 32'hFFFF_FF08);
    rd(12'h1FC, d); chk("R6 cfg31 readback", d, 32'h08);
    set_cfg(5, 32'h0000_0A3F);
    rd(12'h194, d); chk("R6 cfg5 readback", d, 32'h3F);

    // R11: rising edge latency on pin 31
    wr(12'h008, 32'h8000_0000);
    en_m = 32'h8000_0000;
    @(negedge clk);
    pins[31] = 1'b1;
    @(negedge clk);
    rd(12'h100, d); chk("R11 det after 1 edge", d, 0);
    @(negedge clk);
    rd(12'h104, d); chk("R5 monitor after 2 edges", d, 32'h8000_0000);
    rd(12'h100, d); chk("R11 det after 2 edges", d, 0);
    @(negedge clk);
    rd(12'h100, d); chk("R11 det after 3 edges", d, 32'h8000_0000);
    chk("R11 irq after 3 edges", irq, 32'h8000_0000);
    det_m = 32'h8000_0000;

    // R9: undefined code 0x3F on pin 5 senses nothing
    move_pins(pins | 32'h20);
    move_pins(pins & ~32'h20);
    check_all("R9 undefined code");

    // R10: writes to request register ignored
    wr(12'h000, 32'hFFFF_FFFF);
    check_all("R10 write ignored");

    // R7: high level re-sets after clear while active
    set_cfg(2, 32'h02);
    move_pins(pins | 32'h4);
    clear_det(32'h4);
    rd(12'h100, d); chk("R7 high level holds", d & 32'h4, 32'h4);
    move_pins(pins & ~32'h4);
    clear_det(32'h4);
    rd(12'h100, d); chk("R7 high level cleared", d & 32'h4, 0);
    set_cfg(3, 32'h01);
    rd(12'h100, d); chk("R7 low level immediate", d & 32'h8, 32'h8);

    // R8: falling and both edges
    set_cfg(7, 32'h04);
    set_cfg(8, 32'h0C);
    move_pins(pins | 32'h180);
    rd(12'h100, d); chk("R8 fall ignores rise", d & 32'h80, 0);
    chk("R8 both sees rise", d & 32'h100, 32'h100);
    clear_det(32'h180);
    move_pins(pins & ~32'h180);
    rd(12'h100, d); chk("R8 fall sees fall", d & 32'h180, 32'h180);
    check_all("R8 directed");

    // R3: clear mask bit
    wr(12'h004, 32'h8000_0000);
    en_m &= ~32'h8000_0000;
    check_all("R3 directed");

    // Random mix of register writes and pin activity
    for (int r = 0; r < 300; r++) begin
      int act;
      logic [31:0] v;
      act = $urandom_range(0, 4);
      v = $urandom();
      case (act)
        0: begin wr(12'h008, v); en_m |= v; end
        1: begin wr(12'h004, v); en_m &= ~v; end
        2: begin
          int p;
          logic [31:0] c;
          p = $urandom_range(0, NP-1);
          case ($urandom_range(0, 6))
            0: c = 32'h01; 1: c = 32'h02; 2: c = 32'h04;
            3: c = 32'h08; 4: c = 32'h0C; 5: c = 32'h00;
            default: c = v;
          endcase
          set_cfg(p, c);
          rd(12'h180 + 12'(4*p), d);
          chk("R6 random cfg readback", d, {26'b0, c[5:0]});
        end
        3: move_pins(pins ^ (v & $urandom()));
        default: clear_det(v);
      endcase
      if (act != 3 && act != 2) settle();
      check_all("R2 R3 R4 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule